// File: doc/BRIEF.md
# Successive-Approximation Search Engine with Range Clamp

This block is the digital half of a successive-approximation converter. A start pulse launches a binary search over a 12-bit code space, one bit per clock. Each clock the block offers a trial code to an external DAC. It reads back a single comparator decision saying whether the input lies at or above that trial level. It then settles the bit under test, from the most significant bit down to the least significant bit.

When the last bit is decided, the block raises a one-clock done pulse and presents the result in two's complement. The search runs in offset binary, and the output is that code with its top bit inverted. If the analog front end flags an out-of-range input, the result is forced to a full-scale code instead. Overrange gives the positive limit and underrange gives the negative limit.

The range flags are captured together with the start pulse. A start that arrives while a search is running is dropped. The comparator, the DAC and the analog circuitry are outside this block.

Top module: `sar_range_top`

## Requirements
- R1: While reset is asserted and after it is released, with no start seen, `trialCode`, `result` and `donePulse` are all zero.
- R2: One clock after an accepted start, `trialCode` holds only its top bit set (0x800 for 12 bits).
- R3: On each search clock the bit under test is kept when `cmpHigh` is 1 and cleared when it is 0, and the next lower bit is set as the new trial bit. With an ideal comparator (`cmpHigh` = input >= `trialCode`), the final search code equals the input code.
- R4: `donePulse` goes high exactly 12 clocks after the clock edge that accepts the start, and stays high for exactly one clock.
- R5: With neither range flag set, `result` is the search code with its top bit inverted (two's complement). Input code 0x800 gives 0x000, 0x7FF gives 0xFFF, 0x000 gives 0x800, 0x001 gives 0x801, and 0xFFF gives 0x7FF.
- R6: If `overRange` was high when the start was accepted, `result` is 0x7FF. This holds even when `underRange` was also high.
- R7: If `underRange` alone was high when the start was accepted, `result` is 0x800.
- R8: Changing `overRange` or `underRange` after the start has been accepted has no effect on the result of that search.
- R9: A start pulse that arrives while a search is in progress is ignored: it does not alter the running search, its timing or its result, and no extra search or done pulse follows.
- R10: `result` changes only in the clock in which `donePulse` is high. It holds its value through the following search until that search completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | Request to begin a search; honoured only when idle |
| cmpHigh | input | 1 | Comparator decision: 1 when the input is at or above the DAC level |
| overRange | input | 1 | Input above full scale, sampled with an accepted start |
| underRange | input | 1 | Input below full scale, sampled with an accepted start |
| trialCode | output | 12 | Offset-binary code driven to the DAC |
| donePulse | output | 1 | One-clock pulse marking a new result |
| result | output | 12 | Two's-complement conversion result |

## Verification
A wrong bit decision shows up as a bad `trialCode` on the very next clock. It then shows at `result` twelve clocks after the start, as a value that differs from the input code in that bit or below it. A step counter that is off by one moves `donePulse` away from its fixed twelfth-clock position and shifts every lower bit of the result. This is caught by both the latency check and the value check.

A flag latch that follows its input, instead of holding the value captured at the start, is exposed only by flipping the flags mid-search. A busy flag that does not block new starts either restarts the search, which delays done, or adds a second done pulse a dozen clocks later.

// File: rtl/sar_pkg.sv
package sar_pkg;

  // Strobes issued by the sequencer to the datapath each clock.
  typedef struct packed {
    logic loadStart;  // accepted start: arm the top trial bit, capture flags
    logic decide;     // settle the bit under test using the comparator
    logic finish;     // this decision is the last one: publish the result
  } sarStrobe_t;

endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int W = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  output sarStrobe_t strobe,
  output logic       busy,
  output logic       donePulse
);

  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(W - 1);

  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    strobe.loadStart = startPulse & ~busy;
    strobe.decide    = busy;
    strobe.finish    = busy && (stepCnt == LAST_STEP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      stepCnt <= '0;
    end else if (strobe.loadStart) begin
      busy    <= 1'b1;
      stepCnt <= '0;
    end else if (busy) begin
      if (strobe.finish) begin
        busy    <= 1'b0;
        stepCnt <= '0;
      end else begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) donePulse <= 1'b0;
    else       donePulse <= strobe.finish;
  end

endmodule

// File: rtl/sar_clamp.sv
module sar_clamp #(
  parameter int W = 12
) (
  input  logic [W-1:0] searchCode,
  input  logic         ovrHeld,
  input  logic         undHeld,
  output logic [W-1:0] signedCode
);

  localparam logic [W-1:0] POS_FULL = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_FULL = {1'b1, {(W-1){1'b0}}};

  // Overrange has priority over underrange.
  always_comb begin
    if (ovrHeld)      signedCode = POS_FULL;
    else if (undHeld) signedCode = NEG_FULL;
    else              signedCode = {~searchCode[W-1], searchCode[W-2:0]};
  end

endmodule

// File: rtl/sar_dpath.sv
module sar_dpath
  import sar_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  sarStrobe_t   strobe,
  input  logic         cmpHigh,
  input  logic         overRange,
  input  logic         underRange,
  output logic [W-1:0] trialCode,
  output logic [W-1:0] result
);

  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] bitMask;
  logic [W-1:0] keptCode;
  logic [W-1:0] trialNext;
  logic [W-1:0] clampedCode;
  logic         ovrHeld;
  logic         undHeld;

  always_comb begin
    keptCode  = cmpHigh ? trialCode : (trialCode & ~bitMask);
    trialNext = keptCode | (bitMask >> 1);
  end

  sar_clamp #(.W(W)) u_clamp (
    .searchCode (trialNext),
    .ovrHeld    (ovrHeld),
    .undHeld    (undHeld),
    .signedCode (clampedCode)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitMask   <= '0;
      trialCode <= '0;
      ovrHeld   <= 1'b0;
      undHeld   <= 1'b0;
    end else if (strobe.loadStart) begin
      bitMask   <= TOP_BIT;
      trialCode <= TOP_BIT;
      ovrHeld   <= overRange;
      undHeld   <= underRange;
    end else if (strobe.decide) begin
      bitMask   <= bitMask >> 1;
      trialCode <= trialNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              result <= '0;
    else if (strobe.finish) result <= clampedCode;
  end

endmodule

// File: rtl/sar_range_top.sv
module sar_range_top
  import sar_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startPulse,
  input  logic         cmpHigh,
  input  logic         overRange,
  input  logic         underRange,
  output logic [W-1:0] trialCode,
  output logic         donePulse,
  output logic [W-1:0] result
);

  sarStrobe_t strobe;
  logic       busy;

  sar_ctrl #(.W(W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .strobe     (strobe),
    .busy       (busy),
    .donePulse  (donePulse)
  );

  sar_dpath #(.W(W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cmpHigh    (cmpHigh),
    .overRange  (overRange),
    .underRange (underRange),
    .trialCode  (trialCode),
    .result     (result)
  );

endmodule

// File: rtl/sar_range_chk.sv
module sar_range_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rstN,
  input logic         startPulse,
  input logic         cmpHigh,
  input logic         busy,
  input logic [W-1:0] trialCode,
  input logic         donePulse,
  input logic [W-1:0] result
);

  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  AST_FIRST_TRIAL: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !busy) |=> (trialCode == TOP_BIT));  // R2

  AST_KEEP_ON_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmpHigh) |=> ((trialCode & $past(trialCode)) == $past(trialCode)));  // R3

  AST_DROP_ON_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cmpHigh) |=> (trialCode < $past(trialCode)));  // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);  // R4

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !donePulse |-> $stable(result));  // R10

endmodule

bind sar_range_top sar_range_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .cmpHigh    (cmpHigh),
  .busy       (busy),
  .trialCode  (trialCode),
  .donePulse  (donePulse),
  .result     (result)
);

// File: tb/sim_sar_range_top.sv
module sim_sar_range_top;

  localparam int W = 12;
  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startPulse = 1'b0;
  logic         overRange = 1'b0;
  logic         underRange = 1'b0;
  logic [W-1:0] stimV = '0;
  logic [W-1:0] trialCode;
  logic         donePulse;
  logic [W-1:0] result;
  logic         cmpHigh;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] expQ[$];
  logic [W-1:0] lastExp = '0;
  bit havePrev = 0;

  // Ideal comparator model
  assign cmpHigh = (stimV >= trialCode);

  always #5 clk = ~clk;

  sar_range_top #(.W(W)) u0 (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .cmpHigh    (cmpHigh),
    .overRange  (overRange),
    .underRange (underRange),
    .trialCode  (trialCode),
    .donePulse  (donePulse),
    .result     (result)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] expOf(input int v, input bit ovr, input bit und);
    if (ovr)      return W'((1 << (W-1)) - 1);
    else if (und) return W'(1 << (W-1));
    else          return W'(v - (1 << (W-1)));
  endfunction

  // Monitor: compare every delivered result with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && donePulse) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R4 unexpected done", 1, 0);
        end else begin
          logic [W-1:0] e;
          e = expQ.pop_front();
          chk(result == e, "R3/R5/R6/R7/R8/R9 result", int'(result), int'(e));
        end
      end
    end
  end

  task automatic runConv(input int v, input bit ovr, input bit und,
                         input bit flipFlags, input bit midStart);
    int cnt;
    logic [W-1:0] e;
    bit extraDone;
    e = expOf(v, ovr, und);
    @(negedge clk);
    stimV = W'(v); overRange = ovr; underRange = und; startPulse = 1'b1;
    expQ.push_back(e);
    @(negedge clk);
    startPulse = 1'b0;
    chk(trialCode == TOP_BIT, "R2 first trial", int'(trialCode), int'(TOP_BIT));
    if (flipFlags) begin overRange = !ovr; underRange = !und; end
    cnt = 0;
    while (!donePulse && cnt < W + 4) begin
      @(negedge clk);
      cnt++;
      if (midStart && cnt == 5) startPulse = 1'b1;
      if (midStart && cnt == 6) startPulse = 1'b0;
      if (havePrev && cnt == 6)
        chk(result == lastExp, "R10 result held", int'(result), int'(lastExp));
    end
    chk(cnt == W, "R4 done latency", cnt, W);
    @(negedge clk);
    chk(!donePulse, "R4 done width", int'(donePulse), 0);
    if (midStart) begin
      extraDone = 0;
      for (int i = 0; i < W + 2; i++) begin
        @(negedge clk);
        if (donePulse) extraDone = 1;
      end
      chk(!extraDone, "R9 no extra search", int'(extraDone), 0);
    end
    overRange = 1'b0; underRange = 1'b0;
    lastExp = e; havePrev = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(trialCode == '0, "R1 trial in reset", int'(trialCode), 0);
    chk(result == '0, "R1 result in reset", int'(result), 0);
    chk(!donePulse, "R1 done in reset", int'(donePulse), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(trialCode == '0 && result == '0 && !donePulse, "R1 idle after reset",
        int'(trialCode), 0);

    // R5 code boundaries
    runConv(12'h800, 0, 0, 0, 0);
    runConv(12'h7FF, 0, 0, 0, 0);
    runConv(12'h000, 0, 0, 0, 0);
    runConv(12'h001, 0, 0, 0, 0);
    runConv(12'hFFF, 0, 0, 0, 0);
    runConv(12'hA5C, 0, 0, 0, 0);
    runConv(12'h3E7, 0, 0, 0, 0);
    // R3 sweep of patterns
    for (int k = 0; k < 40; k++) runConv((k * 997 + 13) % 4096, 0, 0, 0, 0);
    // R6 / R7 clamps
    runConv(12'h123, 1, 0, 0, 0);
    runConv(12'hE00, 0, 1, 0, 0);
    runConv(12'h456, 1, 1, 0, 0);
    // R8 flags changed after start
    runConv(12'h5A5, 0, 0, 1, 0);
    runConv(12'h0F0, 1, 0, 1, 0);
    runConv(12'hC3C, 0, 1, 1, 0);
    // R9 start while busy
    runConv(12'h6B1, 0, 0, 0, 1);
    runConv(12'h9E2, 0, 0, 0, 1);

    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R4 all results delivered", expQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule